// File: doc/BRIEF.md
# UART byte echo engine

This block pairs an asynchronous serial receiver with a serial transmitter so that every byte arriving on the serial input is sent back out on the serial output. It runs from one system clock (50 MHz by default) with an active-low asynchronous reset. The receive and transmit sides each take their timing from an internal down-counter divider. At the defaults the receive divider fires at twice the 9600 baud bit rate and the transmit divider fires once per bit. A parallel output always shows the last byte received.

The serial input first passes through a two-flop synchronizer. The receiver has four states:
- `RX_IDLE` waits for a low level. Seeing one, it presets its capture buffer to all ones and goes to `RX_START_CHK`.
- `RX_START_CHK`, on the next half-bit tick, goes to `RX_DATA` if the line is still low. If the line is high it goes back to `RX_IDLE`, so a short spike is dropped.
- `RX_DATA` samples one bit on every second tick, least significant bit first. After the last data bit it goes to `RX_STOP_WAIT`.
- `RX_STOP_WAIT`, on the next tick, publishes the byte, raises a one-clock "byte available" pulse and returns to `RX_IDLE`.

The transmitter is enabled by the inverse of that pulse. It has four states:
- `TX_IDLE` holds the line high and its ready flag high. When enabled it latches the byte and goes to `TX_START`.
- `TX_START`, on a bit tick, drives the start bit low and goes to `TX_SHIFT`.
- `TX_SHIFT` drives one data bit per tick. After the eighth bit it goes to `TX_STOP`.
- `TX_STOP`, on a tick, drives the line high, sets ready and returns to `TX_IDLE`.

Top module: `uart_echo`

## Requirements
- R1: While reset is low, and on the first clock after it is released, `tx_serial` is 1 and `rx_byte` is 0. Asserting reset in the middle of a transmitted frame forces `tx_serial` to 1 at once.
- R2: Each divider emits a pulse exactly one system clock wide, once every `RX_DIV` or `TX_DIV` clocks. As a result, every transmitted bit, including the start bit, lasts exactly `TX_DIV` clocks.
- R3: A low level on the serial input that lasts one system clock is dropped by the start check. It produces no byte: `rx_byte` is unchanged and no frame appears on `tx_serial`.
- R4: A received frame at the nominal bit rate updates `rx_byte` to its data byte. Serial bit 1 after the start bit is `rx_byte[0]` and serial bit 8 is `rx_byte[7]`. The byte-available pulse lasts exactly one clock.
- R5: For each received byte, exactly one frame is sent on `tx_serial`. The frame is 0 for one bit time, then the eight data bits with bit 0 first, then a stop level of 1.
- R6: When no frame is being sent, `tx_serial` stays at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_serial | input | 1 | Serial input line, idle high |
| tx_serial | output | 1 | Serial output line carrying the echo, idle high |
| rx_byte | output | DATA_W | Last byte received |

## Verification
A receiver stuck in or skipping `RX_START_CHK` shows within one frame. Either a one-clock glitch turns into a phantom echo frame on `tx_serial`, or real bytes are missed and `rx_byte` keeps its old value. A wrong bit index or shift direction shows as bit errors in `rx_byte` and in the echoed frame as soon as a byte with an asymmetric pattern arrives. A transmitter that miscounts bits or leaves `TX_STOP` too early shows within one frame, as a start bit of the wrong width or a missing stop level. Checking each echoed bit at its mid-point catches any divider that is off by one clock within about one bit time.

// File: rtl/uart_echo_pkg.sv
package uart_echo_pkg;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START_CHK,
        RX_DATA,
        RX_STOP_WAIT
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_SHIFT,
        TX_STOP
    } tx_state_t;

endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
    parameter int DIVISOR = 2604
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIVISOR > 1) ? $clog2(DIVISOR) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(DIVISOR - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q == '0) begin
            cnt_q <= RELOAD;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q - 1'b1;
            tick  <= 1'b0;
        end
    end

    // Spacing checker: cycles since the previous pulse
    logic [31:0] gap_q;
    logic        seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (tick) begin
            gap_q  <= 32'd1;
            seen_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + 32'd1;
        end
    end

    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && seen_q) |-> (gap_q == 32'(DIVISOR)));

    generate
        if (DIVISOR > 1) begin : g_width_chk
            assert_tick_one_wide_R2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/uart_sync2.sv
module uart_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            dout   <= 1'b1;
        end else begin
            meta_q <= din;
            dout   <= meta_q;
        end
    end
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_echo_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxs,
    output logic [DATA_W-1:0] data_o,
    output logic              avail_o
);
    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IW-1:0] LAST = IW'(DATA_W - 1);

    rx_state_t         state_q, state_d;
    logic              half_q;
    logic [IW-1:0]     idx_q;
    logic [DATA_W-1:0] buf_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:      if (!rxs) state_d = RX_START_CHK;
            RX_START_CHK: if (tick) state_d = rxs ? RX_IDLE : RX_DATA;
            RX_DATA:      if (tick && half_q && idx_q == LAST) state_d = RX_STOP_WAIT;
            RX_STOP_WAIT: if (tick) state_d = RX_IDLE;
            default:      state_d = RX_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q   <= '1;
            idx_q   <= '0;
            half_q  <= 1'b0;
            data_o  <= '0;
            avail_o <= 1'b0;
        end else begin
            avail_o <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    idx_q  <= '0;
                    half_q <= 1'b0;
                    if (!rxs) buf_q <= '1;
                end
                RX_START_CHK: begin
                    half_q <= 1'b0;
                end
                RX_DATA: begin
                    if (tick) begin
                        if (half_q) begin
                            buf_q[idx_q] <= rxs;
                            idx_q        <= idx_q + IW'(1);
                            half_q       <= 1'b0;
                        end else begin
                            half_q <= 1'b1;
                        end
                    end
                end
                RX_STOP_WAIT: begin
                    if (tick) begin
                        data_o  <= buf_q;
                        avail_o <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_avail_one_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        avail_o |=> !avail_o);

    assert_avail_from_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(avail_o) |-> ($past(state_q) == RX_STOP_WAIT));

    assert_spike_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_START_CHK && tick && rxs) |=> (state_q == RX_IDLE && !avail_o));

endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_echo_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              send_n,
    input  logic [DATA_W-1:0] data_i,
    output logic              line_o
);
    localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

    tx_state_t         state_q, state_d;
    logic [DATA_W-1:0] sh_q;
    logic [CW-1:0]     cnt_q;
    logic              ready_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (!send_n) state_d = TX_START;
            TX_START: if (tick) state_d = TX_SHIFT;
            TX_SHIFT: if (tick && cnt_q == LAST) state_d = TX_STOP;
            TX_STOP:  if (tick) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_o  <= 1'b1;
            ready_q <= 1'b1;
            sh_q    <= '0;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    line_o  <= 1'b1;
                    cnt_q   <= '0;
                    ready_q <= 1'b1;
                    if (!send_n) begin
                        sh_q    <= data_i;
                        ready_q <= 1'b0;
                    end
                end
                TX_START: begin
                    if (tick) line_o <= 1'b0;
                end
                TX_SHIFT: begin
                    if (tick) begin
                        line_o <= sh_q[0];
                        sh_q   <= sh_q >> 1;
                        cnt_q  <= cnt_q + CW'(1);
                    end
                end
                TX_STOP: begin
                    if (tick) begin
                        line_o  <= 1'b1;
                        ready_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_idle_line_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_IDLE) |-> line_o);

    assert_start_bit_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_START && tick) |=> !line_o);

    assert_ready_low_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != TX_IDLE) |-> !ready_q);

endmodule

// File: rtl/uart_echo.sv
module uart_echo #(
    parameter int RX_DIV = 2604,
    parameter int TX_DIV = 5208,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_serial,
    output logic              tx_serial,
    output logic [DATA_W-1:0] rx_byte
);
    logic rx_tick;
    logic tx_tick;
    logic rx_sync;
    logic rx_avail;

    uart_tick_gen #(.DIVISOR(RX_DIV)) u_rx_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (rx_tick)
    );

    uart_tick_gen #(.DIVISOR(TX_DIV)) u_tx_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tx_tick)
    );

    uart_sync2 u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_serial),
        .dout  (rx_sync)
    );

    uart_rx_fsm #(.DATA_W(DATA_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (rx_tick),
        .rxs     (rx_sync),
        .data_o  (rx_byte),
        .avail_o (rx_avail)
    );

    uart_tx_fsm #(.DATA_W(DATA_W)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tx_tick),
        .send_n (~rx_avail),
        .data_i (rx_byte),
        .line_o (tx_serial)
    );

endmodule

// File: tb/tb_uart_echo.sv
module tb_uart_echo;
    localparam int CLK_PERIOD = 10;
    localparam int RXD   = 8;
    localparam int TXD   = 16;
    localparam int W     = 8;
    localparam int FRAME = 10 * TXD;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rx_line = 1'b1;
    logic         tx_line;
    logic [W-1:0] rx_byte;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_echo #(.RX_DIV(RXD), .TX_DIV(TXD), .DATA_W(W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_serial (rx_line),
        .tx_serial (tx_line),
        .rx_byte   (rx_byte)
    );

    int   checks = 0;
    int   fails  = 0;
    bit   finished = 0;
    bit   got;
    logic s_arr [0:FRAME-1];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected line level for frame position k (0 start, 1..8 data, 9 stop)
    function automatic logic exp_bit(input logic [W-1:0] b, input int k);
        if (k == 0) return 1'b0;
        if (k == 9) return 1'b1;
        return b[k-1];
    endfunction

    task automatic send_frame(input logic [W-1:0] b);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk) rx_line = exp_bit(b, k);
            repeat (TXD - 1) @(negedge clk);
        end
    endtask

    task automatic capture();
        got = 0;
        for (int i = 0; i < 40 * TXD && !got; i++) begin
            @(negedge clk);
            if (!tx_line) got = 1;
        end
        if (got) begin
            s_arr[0] = 1'b0;
            for (int i = 1; i < FRAME; i++) begin
                @(negedge clk);
                s_arr[i] = tx_line;
            end
        end
    endtask

    task automatic idle_gap(input int cycles, input logic [W-1:0] keep, input string req);
        int lows = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (!tx_line) lows++;
        end
        chk(lows == 0, req, "tx low cycles while idle", lows, 0);
        chk(rx_byte == keep, req, "rx_byte unchanged", rx_byte, keep);
    endtask

    task automatic echo_test(input logic [W-1:0] b);
        fork
            send_frame(b);
            capture();
        join
        chk(got, "R5", "echo frame seen", got, 1);
        if (got) begin
            for (int k = 0; k < 10; k++)
                chk(s_arr[k*TXD + TXD/2] == exp_bit(b, k), "R5", "echo bit level",
                    s_arr[k*TXD + TXD/2], exp_bit(b, k));
            if (b[0]) begin
                int w = 0;
                while (w < FRAME && s_arr[w] == 1'b0) w++;
                chk(w == TXD, "R2", "start bit width", w, TXD);
            end
        end
        chk(rx_byte == b, "R4", "rx_byte after frame", rx_byte, b);
        idle_gap(3 * TXD, b, "R6");
    endtask

    initial begin
        logic [W-1:0] last;
        int unsigned  sd;
        sd = $urandom(32'd1357);

        // R1: reset state
        repeat (4) @(negedge clk);
        chk(tx_line == 1'b1, "R1", "tx during reset", tx_line, 1);
        chk(rx_byte == '0, "R1", "rx_byte during reset", rx_byte, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_line == 1'b1, "R1", "tx after reset", tx_line, 1);
        chk(rx_byte == '0, "R1", "rx_byte after reset", rx_byte, 0);
        repeat (2 * TXD) @(negedge clk);

        // R3: one-clock glitch before any byte
        @(negedge clk) rx_line = 1'b0;
        @(negedge clk) rx_line = 1'b1;
        idle_gap(30 * TXD, '0, "R3");

        // Directed corner bytes
        echo_test(8'h00);
        echo_test(8'hFF);
        echo_test(8'hA5);
        echo_test(8'h5A);
        echo_test(8'h01);
        echo_test(8'h80);
        last = 8'h80;

        // R3: glitch after a byte, with a different phase
        repeat (5) @(negedge clk);
        @(negedge clk) rx_line = 1'b0;
        @(negedge clk) rx_line = 1'b1;
        idle_gap(30 * TXD, last, "R3");

        // Random bytes
        for (int n = 0; n < 12; n++) begin
            logic [W-1:0] rb;
            rb = W'($urandom);
            repeat ($urandom % 7) @(negedge clk);
            echo_test(rb);
        end

        // R1: reset in the middle of an echo frame
        send_frame(8'h00);
        got = 0;
        for (int i = 0; i < 4 * TXD && !got; i++) begin
            @(negedge clk);
            if (!tx_line) got = 1;
        end
        chk(got, "R1", "echo began before mid-frame reset", got, 1);
        @(negedge clk) rst_n = 1'b0;
        #1;
        chk(tx_line == 1'b1, "R1", "tx forced high by reset", tx_line, 1);
        chk(rx_byte == '0, "R1", "rx_byte cleared by reset", rx_byte, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle_gap(20 * TXD, '0, "R6");
        echo_test(8'h3C);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL R5 watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule